// File: doc/BRIEF.md
# IR receive FIFO with interrupt status

This block sits between an infrared pulse-width encoder and the register bus. The encoder pushes run-length bytes into a small first-in first-out store, and software drains them by reading a data register. Every read of that register takes one byte out of the store. The block also keeps three sticky event flags for the store: overflow, packet end and data available. It reports how many bytes are held, and it drives one interrupt line. Each flag has its own enable bit.

The data-available flag fires when the fill count rises above a level that software programs. It does not fire merely because the store is non-empty, so software can collect a batch of bytes per interrupt. Sticky flags are cleared by writing ones to them. When a hardware event and a clear reach the same flag together, the event is kept. Dropping the receive-enable input empties the store at once.

Top module: `ir_rxq`

## Requirements
- R1: After reset the fill count, all flags, all enable bits, the level field and `irq` are zero.
- R2: Reading address 0 returns the oldest held byte in bits [7:0], with the upper bits zero, and removes that byte. Bytes come out in the order they were pushed.
- R3: The status word at address 2 carries the number of held bytes in bits [8 +: CNT_W], where CNT_W can represent DEPTH. It is updated on the edge that accepts a push or a pop.
- R4: A push while DEPTH bytes are held, with no pop in the same cycle, is discarded and sets the overflow flag (status bit 0).
- R5: A `push_last` pulse while `rx_on` is high sets the packet-end flag (status bit 4 is not involved; packet end is bit 1).
- R6: The data-available flag (status bit 4) is set on the edge after any cycle in which the fill count is strictly greater than the level field (address 1, bits [8 +: LVL_W]). A count equal to the level does not set it.
- R7: A write to address 2 clears each flag whose bit (0, 1 or 4) is written as one and leaves the other flags unchanged. Writing 0xFF clears all of them.
- R8: When a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R9: `irq` is high exactly while a flag is set whose enable bit at address 1 is set. Enable bit 0 covers overflow, bit 1 covers packet end and bit 4 covers data available.
- R10: While `rx_on` is low the store is emptied (the count reads zero after the next edge), pushes are ignored, and no overflow is raised.
- R11: Reading address 0 while the store is empty returns zero and leaves the count at zero.
- R12: Address 1 reads back the three enable bits at positions 0, 1 and 4 and the level in bits [8 +: LVL_W]. Every other bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_on | input | 1 | Receive enable; low flushes the store |
| push_valid | input | 1 | Encoder byte strobe |
| push_data | input | 8 | Run-length byte from the encoder |
| push_last | input | 1 | Encoder packet-end pulse |
| reg_addr | input | 2 | Register select: 0 data, 1 enables/level, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 0) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, combinational from the current state |
| irq | output | 1 | Interrupt request |

## Verification
The count, the overflow flag and the packet-end flag change on the same edge that samples the push, pop or pulse. The data-available flag lags the count by one further edge, because it compares the registered count. Read data and `irq` are combinational from the registers. The bench therefore drives every stimulus at a falling edge and lets one rising edge pass before it reads the count, overflow or packet end. For data-available it idles one more edge before checking. It samples read data a short delay after setting the address, so each sample falls before the edge that would pop the byte.

// File: rtl/ir_rxq_pkg.sv
package ir_rxq_pkg;
   typedef enum logic [1:0] {
      ADR_DATA = 2'd0,
      ADR_IEN  = 2'd1,
      ADR_STAT = 2'd2,
      ADR_NONE = 2'd3
   } rxq_addr_e;

   // bit positions of the three sources in enable and status words
   localparam int unsigned POS_OVF = 0;
   localparam int unsigned POS_PKT = 1;
   localparam int unsigned POS_AVL = 4;
   localparam int unsigned POS_FLD = 8;

   // internal flag vector order
   localparam int unsigned FI_OVF = 0;
   localparam int unsigned FI_PKT = 1;
   localparam int unsigned FI_AVL = 2;
   localparam int unsigned NFLAG  = 3;
endpackage

// File: rtl/ir_rxq_store.sv
module ir_rxq_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             pop,
   output logic [DW-1:0]    dout,
   output logic [CNT_W-1:0] cnt,
   output logic             full,
   output logic             empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign dout    = mem[rd_ptr];

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("ir_rxq_store: DEPTH must be a power of two");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/ir_rxq_flags.sv
module ir_rxq_flags #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/ir_rxq.sv
module ir_rxq #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned REG_W = 32,
   localparam int unsigned DW    = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned LVL_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_on,
   input  logic             push_valid,
   input  logic [DW-1:0]    push_data,
   input  logic             push_last,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq
);
   import ir_rxq_pkg::*;

   generate
      if (DEPTH != 16 && DEPTH != 64) begin : g_bad_depth
         $error("ir_rxq: DEPTH must be 16 or 64");
      end
      if (REG_W < POS_FLD + CNT_W) begin : g_bad_regw
         $error("ir_rxq: REG_W too narrow for the count field");
      end
   endgenerate

   rxq_addr_e          adr;
   logic [DW-1:0]      head;
   logic [CNT_W-1:0]   fill_cnt;
   logic               is_full, is_empty;
   logic               pop_req;
   logic [NFLAG-1:0]   flg, flg_set, flg_clr, ien_en;
   logic [LVL_W-1:0]   ien_lvl;
   logic [NFLAG-1:0]   wsrc;
   logic               unused_wbits;

   assign adr  = rxq_addr_e'(reg_addr);
   assign wsrc = {reg_wdata[POS_AVL], reg_wdata[POS_PKT], reg_wdata[POS_OVF]};
   assign unused_wbits = ^{reg_wdata[REG_W-1:POS_FLD+LVL_W], reg_wdata[7:5],
                           reg_wdata[3:2]};

   assign pop_req = reg_rd && (adr == ADR_DATA) && rx_on;

   ir_rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!rx_on),
      .push  (push_valid && rx_on),
      .din   (push_data),
      .pop   (pop_req),
      .dout  (head),
      .cnt   (fill_cnt),
      .full  (is_full),
      .empty (is_empty)
   );

   always_comb begin
      flg_set         = '0;
      flg_set[FI_OVF] = rx_on && push_valid && is_full && !pop_req;
      flg_set[FI_PKT] = rx_on && push_last;
      flg_set[FI_AVL] = fill_cnt > {1'b0, ien_lvl};
      flg_clr = (reg_wr && adr == ADR_STAT) ? wsrc : '0;
   end

   ir_rxq_flags #(.N(NFLAG)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flg_set),
      .clr   (flg_clr),
      .flags (flg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_en  <= '0;
         ien_lvl <= '0;
      end else if (reg_wr && adr == ADR_IEN) begin
         ien_en  <= wsrc;
         ien_lvl <= reg_wdata[POS_FLD +: LVL_W];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (adr)
         ADR_DATA: if (!is_empty) reg_rdata[DW-1:0] = head;
         ADR_IEN: begin
            reg_rdata[POS_OVF]           = ien_en[FI_OVF];
            reg_rdata[POS_PKT]           = ien_en[FI_PKT];
            reg_rdata[POS_AVL]           = ien_en[FI_AVL];
            reg_rdata[POS_FLD +: LVL_W]  = ien_lvl;
         end
         ADR_STAT: begin
            reg_rdata[POS_OVF]           = flg[FI_OVF];
            reg_rdata[POS_PKT]           = flg[FI_PKT];
            reg_rdata[POS_AVL]           = flg[FI_AVL];
            reg_rdata[POS_FLD +: CNT_W]  = fill_cnt;
         end
         default: reg_rdata = '0;
      endcase
   end

   assign irq = |(flg & ien_en);
endmodule

// File: rtl/ir_rxq_chk.sv
module ir_rxq_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5,
   parameter int unsigned LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_on,
   input logic             push_valid,
   input logic             push_last,
   input logic             pop,
   input logic [CNT_W-1:0] cnt,
   input logic [2:0]       flags,
   input logic [LVL_W-1:0] lvl
);
   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R4
   overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_on && push_valid && cnt == CNT_W'(DEPTH) && !pop |=> flags[0]);

   // R5
   pkt_end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_on && push_last |=> flags[1]);

   // R6
   avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt > {1'b0, lvl} |=> flags[2]);

   // R10
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_on |=> cnt == '0);
endmodule

bind ir_rxq ir_rxq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_on      (rx_on),
   .push_valid (push_valid),
   .push_last  (push_last),
   .pop        (pop_req),
   .cnt        (fill_cnt),
   .flags      (flg),
   .lvl        (ien_lvl)
);

// File: tb/test_ir_rxq.sv
`timescale 1ns/1ps
module test_ir_rxq;
   localparam int DEPTH = 16;
   localparam int REG_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_on = 1'b0;
   logic             push_valid = 1'b0;
   logic [7:0]       push_data = '0;
   logic             push_last = 1'b0;
   logic [1:0]       reg_addr = 2'd3;
   logic             reg_wr = 1'b0;
   logic             reg_rd = 1'b0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic             irq;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   ir_rxq #(.DEPTH(DEPTH), .REG_W(REG_W)) i_ir_rxq (
      .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .push_valid(push_valid),
      .push_data(push_data), .push_last(push_last), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   // op[34:32] arg[31:16] exp[15:0]; ops: 0 push, 1 pop, 2 status, 3 enable write, 4 status write
   localparam int NV = 11;
   localparam logic [34:0] VEC [NV] = '{
      {3'd3, 16'h0213, 16'h0000},
      {3'd0, 16'h00A5, 16'h0001},
      {3'd0, 16'h003C, 16'h0002},
      {3'd0, 16'h0081, 16'h0003},
      {3'd2, 16'h0000, 16'h0310},
      {3'd1, 16'h0000, 16'h00A5},
      {3'd1, 16'h0000, 16'h003C},
      {3'd2, 16'h0000, 16'h0110},
      {3'd4, 16'h0010, 16'h0000},
      {3'd1, 16'h0000, 16'h0081},
      {3'd2, 16'h0000, 16'h0000}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      push_valid = 1'b1; push_data = b;
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic pop(output logic [31:0] v);
      @(negedge clk);
      reg_addr = 2'd0; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0; reg_addr = 2'd3;
   endtask

   task automatic rdreg(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
      reg_addr = 2'd3;
   endtask

   task automatic wrreg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd3; reg_wdata = '0;
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; rx_on = 1'b1;
      tick();

      // R1 reset state
      rdreg(2'd2, v); check("R1 status", v, 32'h0);
      rdreg(2'd1, v); check("R1 enables", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [2:0]  op;
         logic [15:0] arg, exp;
         {op, arg, exp} = VEC[i];
         case (op)
            3'd0: begin push(arg[7:0]); rdreg(2'd2, v); check("R3 count", {16'b0, 8'b0, v[15:8]}, {16'b0, exp}); end
            3'd1: begin pop(v); check("R2 data", v, {16'b0, exp}); end
            3'd2: begin tick(); rdreg(2'd2, v); check("R6 status", v, {16'b0, exp}); end
            3'd3: begin wrreg(2'd1, {16'b0, arg}); check("R9 irq", {31'b0, irq}, {16'b0, exp}); end
            default: begin wrreg(2'd2, {16'b0, arg}); check("R7 irq", {31'b0, irq}, {16'b0, exp}); end
         endcase
      end

      // R12 enable readback masks unused bits
      wrreg(2'd1, 32'hFFFF_FFFF);
      rdreg(2'd1, v); check("R12 enables", v, 32'h0000_0F13);

      // R4 overflow when full, R9 irq from overflow
      wrreg(2'd1, 32'h0000_0001);
      for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i));
      rdreg(2'd2, v); check("R4 full no ovf", {31'b0, v[0]}, 32'h0);
      check("R3 full count", {24'b0, v[15:8]}, DEPTH);
      push(8'hEE);
      rdreg(2'd2, v); check("R4 ovf set", {31'b0, v[0]}, 32'h1);
      check("R4 count held", {24'b0, v[15:8]}, DEPTH);
      check("R9 irq ovf", {31'b0, irq}, 32'h1);
      for (int i = 0; i < DEPTH; i++) begin
         pop(v); check("R2 order", v, 32'h40 + i);
      end
      // R11 empty read
      pop(v); check("R11 empty data", v, 32'h0);
      rdreg(2'd2, v); check("R11 count", {24'b0, v[15:8]}, 32'h0);

      // R5 packet end, R7 partial clear
      wrreg(2'd2, 32'hFF);
      @(negedge clk); push_last = 1'b1;
      @(negedge clk); push_last = 1'b0;
      rdreg(2'd2, v); check("R5 pkt", {31'b0, v[1]}, 32'h1);
      wrreg(2'd2, 32'h01);
      rdreg(2'd2, v); check("R7 partial", {30'b0, v[1:0]}, 32'h2);
      wrreg(2'd2, 32'hFF);
      rdreg(2'd2, v); check("R7 all", v, 32'h0);

      // R8 set wins over clear
      @(negedge clk);
      push_last = 1'b1; reg_addr = 2'd2; reg_wdata = 32'hFF; reg_wr = 1'b1;
      @(negedge clk);
      push_last = 1'b0; reg_wr = 1'b0; reg_addr = 2'd3;
      rdreg(2'd2, v); check("R8 set wins", {31'b0, v[1]}, 32'h1);

      // R6 boundary: count equal to level does not set
      wrreg(2'd1, 32'h0000_0210);
      wrreg(2'd2, 32'hFF);
      push(8'h01); push(8'h02); tick();
      rdreg(2'd2, v); check("R6 equal", {31'b0, v[4]}, 32'h0);
      check("R9 irq quiet", {31'b0, irq}, 32'h0);
      push(8'h03); tick();
      rdreg(2'd2, v); check("R6 above", {31'b0, v[4]}, 32'h1);
      check("R9 irq avail", {31'b0, irq}, 32'h1);

      // R10 flush and ignore while disabled
      @(negedge clk); rx_on = 1'b0;
      tick();
      wrreg(2'd2, 32'hFF);
      push(8'h11);
      rdreg(2'd2, v); check("R10 flushed", v, 32'h0);
      @(negedge clk); rx_on = 1'b1;
      push(8'h77);
      pop(v); check("R10 fresh data", v, 32'h77);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule